// File: doc/BRIEF.md
# Early Receive Event Interrupt Logic

This block follows a received Ethernet frame byte by byte while the frame is being buffered. It tells the host early that a frame is arriving. It raises an early event when the destination address of the frame has been accepted by the address filter, and a second early event when the frame's 128th byte has arrived. The early event bits clear themselves: the 128-byte event replaces the address event, and the end of the frame removes the 128-byte event. The host can also clear both by reading the buffer event word.

Beside the early events the block keeps one ordinary sticky "frame received" event. It is raised at the end of a frame that passed acceptance, and only a read of the receive event word clears it. A level interrupt is the OR of every set event bit whose enable is on.

Top module: `erx_early_irq`

## Requirements
- R1: After a synchronous active-low reset, `bufevt` is all zero, `rxok_evt` is 0 and `irq` is 0. Bits of `bufevt` other than 15 and 11 are always 0.
- R2: The destination event (bit 15 of `bufevt`) is 1 from the clock edge that samples `da_hit` high. The exception is the case where that same edge also sets the 128-byte event.
- R3: The 128-byte event (bit 11 of `bufevt`) is 1 from the edge that samples the 128th `rx_byte` strobe since the last `rx_sof`. It fires at most once per frame, and a strobe sampled together with `rx_sof` counts as byte 1.
- R4: The edge that sets the 128-byte event clears the destination event, even when `da_hit` is high on that same edge.
- R5: The 128-byte event clears on an edge that samples `rx_eof` or `bufevt_rd`.
- R6: The destination event clears on an edge that samples `bufevt_rd`. `rx_eof` leaves it unchanged.
- R7: When a set condition and a clearing read arrive on the same edge, the event bit ends up set.
- R8: `rxok_evt` sets on an edge that samples `rx_eof` with `rx_keep` high. With `rx_keep` low the edge leaves it unchanged. `bufevt_rd` does not affect it, and only `rxevt_rd` clears it.
- R9: The byte count saturates at 1518. A frame longer than that still raises `rxok_evt` at its end, and no second 128-byte event occurs.
- R10: `irq` equals the OR of (`bufevt` AND `bufcfg`) and (`rxok_evt` AND `rxok_ie`). The enables sit at bit 15 and bit 11 of `bufcfg`. `irq` follows the event bits and the enables without an extra register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_sof | input | 1 | Start of a new frame, restarts the byte count |
| rx_byte | input | 1 | One received byte buffered this cycle |
| da_hit | input | 1 | Destination address passed the address filter |
| rx_eof | input | 1 | End of the incoming frame |
| rx_keep | input | 1 | Acceptance result, valid with `rx_eof` |
| bufevt_rd | input | 1 | Host read of the buffer event word |
| rxevt_rd | input | 1 | Host read of the receive event word |
| bufcfg | input | 16 | Buffer configuration word, enables at bits 15 and 11 |
| rxok_ie | input | 1 | Enable for the frame-received event |
| bufevt | output | 16 | Buffer event word, early events at bits 15 and 11 |
| rxok_evt | output | 1 | Sticky frame-received event |
| irq | output | 1 | Level interrupt request |

## Verification
Two sets of functions can coincide on one edge. The first is an event's setting and the host's clearing read. The second is the 128-byte event's setting and the destination event's setting. The bench drives `da_hit` or `rx_eof` together with a read strobe, and it drives the 128th byte together with `bufevt_rd` or with `da_hit`. After each such edge it judges the outcome from the bits: the set must win over the read, and the 128-byte event must win over the destination event.

// File: rtl/erx_pkg.sv
// Package: bit positions and sizes shared by the early receive event logic.
// Assumes a 16-bit event/config word layout with early events at 15 and 11.
package erx_pkg;
    localparam int EVW      = 16;
    localparam int DEST_BIT = 15;
    localparam int B128_BIT = 11;
endpackage

// File: rtl/erx_bytecnt.sv
// Byte counter: counts received bytes of the current frame and saturates at
// MAX_LEN. It pulses hit_thr on the strobe that carries byte number THRESH.
// Assumes rx_sof marks the first cycle of a frame (a byte may come with it).
module erx_bytecnt #(
    parameter int MAX_LEN = 1518,
    parameter int THRESH  = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_sof,
    input  logic rx_byte,
    output logic hit_thr
);
    localparam int CW = $clog2(MAX_LEN + 1);
    localparam logic [CW-1:0] MAXV = CW'(MAX_LEN);
    localparam logic [CW-1:0] THRM1 = CW'(THRESH - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] base;

    // Count origin: a new frame starts from zero.
    always_comb base = rx_sof ? '0 : cnt_q;

    // Threshold pulse on the byte that brings the count to THRESH.
    always_comb hit_thr = rx_byte && (base == THRM1);

    // Saturating byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (rx_byte)
            cnt_q <= (base == MAXV) ? MAXV : base + 1'b1;
        else if (rx_sof)
            cnt_q <= '0;
    end

    a_r9_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MAXV);
    a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit_thr |=> !hit_thr);
endmodule

// File: rtl/erx_early.sv
// Early event bits: destination-address event and 128-byte event. Both clear
// on a host read; the 128-byte event also clears at end of frame and clears
// the destination event when it sets. A set always wins over a clear.
module erx_early (
    input  logic clk,
    input  logic rst_n,
    input  logic da_hit,
    input  logic hit_thr,
    input  logic rx_eof,
    input  logic host_rd,
    output logic dest_evt,
    output logic b128_evt
);
    logic dest_d, b128_d;

    // Next state for the destination event.
    always_comb begin
        dest_d = dest_evt;
        if (hit_thr)
            dest_d = 1'b0;
        else if (da_hit)
            dest_d = 1'b1;
        else if (host_rd)
            dest_d = 1'b0;
    end

    // Next state for the 128-byte event.
    always_comb begin
        b128_d = b128_evt;
        if (hit_thr)
            b128_d = 1'b1;
        else if (rx_eof || host_rd)
            b128_d = 1'b0;
    end

    // Event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_evt <= 1'b0;
            b128_evt <= 1'b0;
        end else begin
            dest_evt <= dest_d;
            b128_evt <= b128_d;
        end
    end

    a_r2_dest_set: assert property (@(posedge clk) disable iff (!rst_n)
        (da_hit && !hit_thr) |=> dest_evt);
    a_r4_dest_clr: assert property (@(posedge clk) disable iff (!rst_n)
        hit_thr |=> (b128_evt && !dest_evt));
    a_r5_b128_clr: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_eof || host_rd) && !hit_thr) |=> !b128_evt);
    a_r6_dest_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !da_hit) |=> !dest_evt);
endmodule

// File: rtl/erx_frame.sv
// Sticky frame-received event: set at the end of an accepted frame and
// cleared only by a read of the receive event word; the set wins.
module erx_frame (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_eof,
    input  logic rx_keep,
    input  logic rd,
    output logic ok_evt
);
    // Sticky event register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ok_evt <= 1'b0;
        else if (rx_eof && rx_keep)
            ok_evt <= 1'b1;
        else if (rd)
            ok_evt <= 1'b0;
    end

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_evt && !rd) |=> ok_evt);
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_eof && rx_keep) |=> ok_evt);
endmodule

// File: rtl/erx_early_irq.sv
// Top: early receive event interrupt logic. Wires the byte counter, the early
// event bits and the sticky frame event, and builds the level interrupt.
// Assumes the strobes are single-cycle and synchronous to clk.
module erx_early_irq #(
    parameter int MAX_LEN = 1518,
    parameter int THRESH  = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_sof,
    input  logic        rx_byte,
    input  logic        da_hit,
    input  logic        rx_eof,
    input  logic        rx_keep,
    input  logic        bufevt_rd,
    input  logic        rxevt_rd,
    input  logic [15:0] bufcfg,
    input  logic        rxok_ie,
    output logic [15:0] bufevt,
    output logic        rxok_evt,
    output logic        irq
);
    import erx_pkg::*;

    logic hit_thr, dest_evt, b128_evt;

    erx_bytecnt #(.MAX_LEN(MAX_LEN), .THRESH(THRESH)) u_cnt (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_byte(rx_byte),
        .hit_thr(hit_thr)
    );

    erx_early u_early (
        .clk(clk), .rst_n(rst_n), .da_hit(da_hit), .hit_thr(hit_thr),
        .rx_eof(rx_eof), .host_rd(bufevt_rd),
        .dest_evt(dest_evt), .b128_evt(b128_evt)
    );

    erx_frame u_frame (
        .clk(clk), .rst_n(rst_n), .rx_eof(rx_eof), .rx_keep(rx_keep),
        .rd(rxevt_rd), .ok_evt(rxok_evt)
    );

    // Place the early bits in the event word.
    always_comb begin
        bufevt = '0;
        bufevt[DEST_BIT] = dest_evt;
        bufevt[B128_BIT] = b128_evt;
    end

    // Level interrupt from every enabled event bit.
    always_comb irq = (|(bufevt & bufcfg)) | (rxok_evt & rxok_ie);

    a_r10_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!dest_evt && !b128_evt && !rxok_evt) |-> !irq);
    a_r1_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bufevt) <= 2);
endmodule

// File: tb/sim_erx_early_irq.sv
`timescale 1ns/1ps
module sim_erx_early_irq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_sof = 0, rx_byte = 0, da_hit = 0, rx_eof = 0, rx_keep = 0;
    logic bufevt_rd = 0, rxevt_rd = 0, rxok_ie = 1'b1;
    logic [15:0] bufcfg = 16'h8800;
    logic [15:0] bufevt;
    logic rxok_evt, irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    erx_early_irq u0 (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_byte(rx_byte),
        .da_hit(da_hit), .rx_eof(rx_eof), .rx_keep(rx_keep),
        .bufevt_rd(bufevt_rd), .rxevt_rd(rxevt_rd), .bufcfg(bufcfg),
        .rxok_ie(rxok_ie), .bufevt(bufevt), .rxok_evt(rxok_evt), .irq(irq)
    );

    // {sof,byte,da,eof,keep,brd,rrd, exp_dest,exp_b128,exp_rxok,exp_irq}
    localparam int NV = 11;
    localparam logic [10:0] VEC [NV] = '{
        11'b1000000_0000, // R1 new frame, nothing set
        11'b0010000_1001, // R2 dest sets
        11'b0000010_0000, // R6 read clears dest
        11'b0010010_1001, // R7 dest set wins over read
        11'b0001100_1011, // R8 accepted end, R6 dest kept on eof
        11'b0000010_0011, // R8 buffer read leaves rxok
        11'b0000001_0000, // R8 receive read clears rxok
        11'b1000000_0000, // R1 next frame
        11'b0001000_0000, // R8 rejected frame, no event
        11'b0001101_0011, // R7 rxok set wins over read
        11'b0000001_0000  // R8 cleared
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic s, b, d, e, k, br, rr);
        rx_sof = s; rx_byte = b; da_hit = d; rx_eof = e; rx_keep = k;
        bufevt_rd = br; rxevt_rd = rr;
        @(posedge clk); #1;
        rx_sof = 0; rx_byte = 0; da_hit = 0; rx_eof = 0; rx_keep = 0;
        bufevt_rd = 0; rxevt_rd = 0;
    endtask

    task automatic bytes(input int n);
        for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 bufevt", bufevt, 16'h0);
        chk("R1 rxok", rxok_evt, 0);
        chk("R1 irq", irq, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [10:0] t;
            t = VEC[v];
            cyc(t[10], t[9], t[8], t[7], t[6], t[5], t[4]);
            chk($sformatf("R2/R6/R7/R8 vec%0d dest", v), bufevt[15], t[3]);
            chk($sformatf("R3/R5 vec%0d b128", v), bufevt[11], t[2]);
            chk($sformatf("R8 vec%0d rxok", v), rxok_evt, t[1]);
            chk($sformatf("R10 vec%0d irq", v), irq, t[0]);
        end

        // R3/R4: 128th byte sets b128 and clears dest
        cyc(1, 1, 1, 0, 0, 0, 0);
        bytes(126);
        chk("R3 before 128", bufevt, 16'h8000);
        bytes(1);
        chk("R3 R4 at 128", bufevt, 16'h0800);
        chk("R10 irq b128", irq, 1);
        // R10 enable position
        bufcfg = 16'h8000; #1;
        chk("R10 b128 disabled", irq, 0);
        bufcfg = 16'h0800; #1;
        chk("R10 b128 enabled", irq, 1);
        bufcfg = 16'h8800;
        // R5 read clears; R3 no refire; R9 long frame
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R5 read clears b128", bufevt, 16'h0);
        bytes(1900);
        chk("R3 R9 no second event", bufevt, 16'h0);
        cyc(0, 0, 0, 1, 1, 0, 0);
        chk("R9 long frame rxok", rxok_evt, 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        chk("R8 rxok cleared", rxok_evt, 0);

        // R5 eof clears b128
        cyc(1, 1, 0, 0, 0, 0, 0);
        bytes(127);
        chk("R3 set again", bufevt, 16'h0800);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk("R5 eof clears b128", bufevt, 16'h0);
        chk("R8 rejected", rxok_evt, 0);

        // R7 128th byte with read; R4 with da_hit
        cyc(1, 1, 0, 0, 0, 0, 0);
        bytes(126);
        cyc(0, 1, 0, 0, 0, 1, 0);
        chk("R7 b128 set wins", bufevt, 16'h0800);
        cyc(1, 1, 0, 0, 0, 0, 0);
        bytes(126);
        cyc(0, 1, 1, 0, 0, 0, 0);
        chk("R4 b128 over dest", bufevt, 16'h0800);
        // R10 rxok enable
        cyc(0, 0, 0, 1, 1, 0, 0);
        bufcfg = 16'h0000; rxok_ie = 0; #1;
        chk("R10 all disabled", irq, 0);
        rxok_ie = 1; #1;
        chk("R10 rxok enabled", irq, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule